// File: doc/BRIEF.md
# Minifloat to Signed Integer Converter

This block turns a 17-bit floating-point word into a 12-bit two's-complement integer. The word has a sign in the top bit, a 6-bit exponent biased by 31 and a 10-bit fraction. The fraction carries an implied leading one. The block restores that one and removes the bias. It then keeps only the integer part of the value, dropping any fraction bits. A negative sign produces the two's complement of the result. Values too large for 12 bits clamp to the largest or smallest integer.

Words arrive with a valid strobe, one per clock if needed. Each result leaves a registered output, marked by its own valid flag, exactly three clocks after the input was sampled. The output holds its last value while no result is due. An asynchronous active-low reset clears the pipeline. Inside the block, reset is released in step with the clock.

Top module: `minifloat_to_int`

## Requirements
- R1: Input bit 16 is the sign, bits 15:10 hold the biased exponent e and bits 9:0 hold the fraction f. With k = e - 31 and 0 <= k <= 10, a positive input yields floor((1024 + f) * 2^k / 1024).
- R2: An exponent field of 0 yields 0, whatever the sign and fraction are.
- R3: A nonzero exponent field with k < 0 (e from 1 to 30) yields 0, for either sign.
- R4: k > 10 (e from 42 to 63) yields +2047 when the sign is 0 and -2048 (12'h800) when the sign is 1.
- R5: A sign of 1 with 0 <= k <= 10 yields the 12-bit two's complement of the R1 magnitude, so bit 11 of a nonzero negative result is 1.
- R6: out_valid is high exactly 3 clock edges after an edge that samples in_valid high, and low otherwise. out_data changes only when out_valid is high.
- R7: While rst_n is low, and until the first valid input has passed through, out_valid is 0.
- R8: Back-to-back valid inputs give back-to-back results in input order, one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 17 | Floating-point input: sign, exponent, fraction |
| out_valid | output | 1 | out_data carries a new result |
| out_data | output | 12 | Two's-complement integer result |

## Verification
Several kinds of input are applied, and each tells a different fault apart:
- Exponents at k = 0, 3, 5 and 10, with fractions that have set low bits. These reveal a shift that is off by one, and truncation that rounds instead.
- The same magnitudes with the sign set. These separate a correct negation from sign-magnitude output or a missing sign.
- Exponent 0, exponent 30 and exponent 1. These show whether the zero path and the below-one path really return 0 for both signs.
- Exponents 42 and 63 with both signs. These expose saturation that is wrong or missing at the top end of the range.
- A stream with gaps, plus a period with in_valid low. These show whether the valid pipeline keeps order and latency, and whether the output holds between results.

// File: rtl/minifloat_pkg.sv
package minifloat_pkg;
  // Classification of the input range decided in the first stage
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_SAT  = 2'd2
  } mf_cls_e;
endpackage

// File: rtl/mf_rst_sync.sv
module mf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/mf_unpack.sv
module mf_unpack
  import minifloat_pkg::*;
#(
  parameter int EXP_W  = 6,
  parameter int FRAC_W = 10,
  parameter int OUT_W  = 12,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = OUT_W - 1,
  localparam int KW     = $clog2(MAG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              s1_valid,
  output logic              s1_sign,
  output mf_cls_e           s1_cls,
  output logic [FRAC_W:0]   s1_sig,
  output logic [KW-1:0]     s1_k
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int MAX_K = MAG_W - 1;

  logic [EXP_W-1:0] exp_f;
  int               unb;
  mf_cls_e          cls_nxt;
  logic [KW-1:0]    k_nxt;
  logic [FRAC_W:0]  sig_nxt;

  always_comb begin
    exp_f   = in_word[FRAC_W +: EXP_W];
    unb     = int'(exp_f) - BIAS;
    sig_nxt = {1'b1, in_word[FRAC_W-1:0]};
    k_nxt   = '0;
    if (exp_f == '0) begin
      cls_nxt = CLS_ZERO;
    end else if (unb < 0) begin
      cls_nxt = CLS_ZERO;
    end else if (unb > MAX_K) begin
      cls_nxt = CLS_SAT;
    end else begin
      cls_nxt = CLS_NORM;
      k_nxt   = KW'(unb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_sign <= in_word[WORD_W-1];
      s1_cls  <= cls_nxt;
      s1_sig  <= sig_nxt;
      s1_k    <= k_nxt;
    end
  end
endmodule

// File: rtl/mf_align.sv
module mf_align
  import minifloat_pkg::*;
#(
  parameter int FRAC_W = 10,
  parameter int OUT_W  = 12,
  localparam int MAG_W  = OUT_W - 1,
  localparam int KW     = $clog2(MAG_W),
  localparam int WIDE_W = FRAC_W + OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic             s1_sign,
  input  mf_cls_e          s1_cls,
  input  logic [FRAC_W:0]  s1_sig,
  input  logic [KW-1:0]    s1_k,
  output logic             s2_valid,
  output logic             s2_sign,
  output logic             s2_sat,
  output logic [MAG_W-1:0] s2_mag
);
  logic [WIDE_W-1:0] wide;
  logic [MAG_W-1:0]  mag_nxt;
  logic              sat_nxt;

  // Moving the significand up by k and down by the fraction width keeps
  // exactly k+1 integer bits and truncates the rest.
  always_comb begin
    wide    = WIDE_W'(s1_sig) << s1_k;
    mag_nxt = MAG_W'(wide >> FRAC_W);
    sat_nxt = (s1_cls == CLS_SAT);
    if (s1_cls != CLS_NORM) begin
      mag_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_sign <= s1_sign;
      s2_sat  <= sat_nxt;
      s2_mag  <= mag_nxt;
    end
  end
endmodule

// File: rtl/mf_apply_sign.sv
module mf_apply_sign #(
  parameter int OUT_W = 12,
  localparam int MAG_W = OUT_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s2_valid,
  input  logic             s2_sign,
  input  logic             s2_sat,
  input  logic [MAG_W-1:0] s2_mag,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {MAG_W{1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {MAG_W{1'b0}}};

  logic [OUT_W-1:0] data_nxt;

  always_comb begin
    if (s2_sat) begin
      data_nxt = s2_sign ? NEG_MIN : POS_MAX;
    end else if (s2_sign) begin
      data_nxt = OUT_W'(0) - {1'b0, s2_mag};
    end else begin
      data_nxt = {1'b0, s2_mag};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s2_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      out_data <= data_nxt;
    end
  end
endmodule

// File: rtl/minifloat_to_int.sv
module minifloat_to_int
  import minifloat_pkg::*;
#(
  parameter int EXP_W  = 6,
  parameter int FRAC_W = 10,
  parameter int OUT_W  = 12,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = OUT_W - 1,
  localparam int KW     = $clog2(MAG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  logic             rst_n_sync;
  logic             s1_valid, s1_sign;
  mf_cls_e          s1_cls;
  logic [FRAC_W:0]  s1_sig;
  logic [KW-1:0]    s1_k;
  logic             s2_valid, s2_sign, s2_sat;
  logic [MAG_W-1:0] s2_mag;

  mf_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mf_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) i_unpack (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .in_valid (in_valid),
    .in_word  (in_word),
    .s1_valid (s1_valid),
    .s1_sign  (s1_sign),
    .s1_cls   (s1_cls),
    .s1_sig   (s1_sig),
    .s1_k     (s1_k)
  );

  mf_align #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) i_align (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .s1_valid (s1_valid),
    .s1_sign  (s1_sign),
    .s1_cls   (s1_cls),
    .s1_sig   (s1_sig),
    .s1_k     (s1_k),
    .s2_valid (s2_valid),
    .s2_sign  (s2_sign),
    .s2_sat   (s2_sat),
    .s2_mag   (s2_mag)
  );

  mf_apply_sign #(.OUT_W(OUT_W)) i_apply_sign (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .s2_valid  (s2_valid),
    .s2_sign   (s2_sign),
    .s2_sat    (s2_sat),
    .s2_mag    (s2_mag),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/minifloat_to_int_chk.sv
module minifloat_to_int_chk #(
  parameter int EXP_W  = 6,
  parameter int FRAC_W = 10,
  parameter int OUT_W  = 12,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_data
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int SAT_E = BIAS + OUT_W - 1;
  localparam int GUARD = 5; // pipeline depth plus reset release delay

  logic [3:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
    end else if (cyc != 4'hF) begin
      cyc <= cyc + 4'd1;
    end
  end

  // R6: fixed latency of three edges
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= GUARD) |-> (out_valid == $past(in_valid, 3)));

  // R2: zero exponent field gives zero
  a_r2_zero_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= GUARD && out_valid && $past(in_word[FRAC_W +: EXP_W], 3) == '0)
    |-> (out_data == '0));

  // R3: exponents below the bias give zero
  a_r3_below_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= GUARD && out_valid && $past(in_word[FRAC_W +: EXP_W], 3) < EXP_W'(BIAS))
    |-> (out_data == '0));

  // R4: large exponents clamp
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= GUARD && out_valid && $past(in_word[FRAC_W +: EXP_W], 3) > EXP_W'(SAT_E))
    |-> (out_data == ($past(in_word[WORD_W-1], 3) ? {1'b1, {(OUT_W-1){1'b0}}}
                                                    : {1'b0, {(OUT_W-1){1'b1}}})));

  // R5: nonzero result carries the input sign
  a_r5_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= GUARD && out_valid && out_data != '0)
    |-> (out_data[OUT_W-1] == $past(in_word[WORD_W-1], 3)));

  // R7: no result right after reset
  a_r7_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc < 3) |-> !out_valid);
endmodule

bind minifloat_to_int minifloat_to_int_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_minifloat_to_int.sv
module test_minifloat_to_int;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [16:0] in_word;
  logic        out_valid;
  logic [11:0] out_data;

  int n_checks;
  int n_fail;
  bit done;

  minifloat_to_int i_minifloat_to_int (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [16:0] mk(input bit s, input int e, input int f);
    return {s, 6'(e), 10'(f)};
  endfunction

  // Independent model of the requirements
  function automatic logic [11:0] model(input logic [16:0] w);
    int e, k, mag, res;
    e = int'(w[15:10]);
    if (e == 0) return 12'd0;
    k = e - 31;
    if (k < 0) return 12'd0;
    if (k > 10) return w[16] ? 12'h800 : 12'h7FF;
    mag = ((1024 + int'(w[9:0])) * (1 << k)) / 1024;
    res = w[16] ? -mag : mag;
    return 12'(res);
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_word  = '0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 out_valid in reset", 12'(out_valid), 12'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 out_valid after release", 12'(out_valid), 12'd0);
  endtask

  // One isolated conversion with latency check
  task automatic t_one(input string req, input logic [16:0] w);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = ~w;
    @(negedge clk);
    chk({req, " R6 valid early"}, 12'(out_valid), 12'd0);
    @(negedge clk);
    chk({req, " R6 valid on time"}, 12'(out_valid), 12'd1);
    chk(req, out_data, model(w));
    @(negedge clk);
    chk({req, " R6 valid single"}, 12'(out_valid), 12'd0);
  endtask

  // Output must hold while in_valid stays low
  task automatic t_hold();
    logic [11:0] held;
    t_one("R1 hold setup", mk(0, 36, 10'h155));
    held = out_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_word = mk(1, 40 - i, i * 77);
    end
    chk("R6 hold value", out_data, held);
    chk("R6 hold valid low", 12'(out_valid), 12'd0);
  endtask

  // Back-to-back stream with one gap
  task automatic t_stream();
    logic [16:0] w[8];
    bit          v[8];
    w[0] = mk(0, 31, 0);      v[0] = 1;
    w[1] = mk(1, 33, 10'h200); v[1] = 1;
    w[2] = mk(0, 45, 3);      v[2] = 1;
    w[3] = mk(0, 20, 7);      v[3] = 0;
    w[4] = mk(1, 63, 0);      v[4] = 1;
    w[5] = mk(0, 38, 10'h3FF); v[5] = 1;
    w[6] = mk(1, 0, 10'h111);  v[6] = 1;
    w[7] = mk(1, 41, 10'h3FF); v[7] = 1;
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk("R8 stream valid", 12'(out_valid), 12'(v[i-3]));
        if (v[i-3]) chk("R8 stream data", out_data, model(w[i-3]));
      end
      if (i < 8) begin
        in_word  = w[i];
        in_valid = v[i];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  // Reset with data in flight
  task automatic t_reset_mid();
    @(negedge clk);
    in_word  = mk(0, 35, 5);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 flushed by reset", 12'(out_valid), 12'd0);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 0;
    do_reset();
    t_one("R1 k=0 one", mk(0, 31, 0));
    t_one("R1 k=3 truncate", mk(0, 34, 1));
    t_one("R1 k=3 frac", mk(0, 34, 10'h180));
    t_one("R1 k=5", mk(0, 36, 10'h200));
    t_one("R1 k=10 max", mk(0, 41, 10'h3FF));
    t_one("R5 k=5 negative", mk(1, 36, 10'h200));
    t_one("R5 k=10 negative", mk(1, 41, 10'h3FF));
    t_one("R5 k=0 negative", mk(1, 31, 10'h3FF));
    t_one("R2 zero exp pos", mk(0, 0, 10'h3FF));
    t_one("R2 zero exp neg", mk(1, 0, 10'h2AA));
    t_one("R3 exp 30", mk(0, 30, 10'h3FF));
    t_one("R3 exp 1 neg", mk(1, 1, 10'h001));
    t_one("R4 exp 42 pos", mk(0, 42, 0));
    t_one("R4 exp 42 neg", mk(1, 42, 0));
    t_one("R4 exp 63 pos", mk(0, 63, 0));
    t_one("R4 exp 63 neg", mk(1, 63, 10'h3FF));
    t_hold();
    t_stream();
    t_reset_mid();
    t_one("R1 after reset", mk(0, 39, 10'h0F0));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule